// File: doc/BRIEF.md
# Transmit Status Flag Unit

This block produces the two transmit-side status flags of a buffered serial transmitter. The first, the room flag, tells software that the transmit buffer has drained to or below a programmable watermark. The second, the done flag, tells software that the transmitter has gone completely quiet: the buffer is empty, and no data, preamble or break is being shifted out. While the done flag is set, the block also asks for the serial line to be held at the mark (logic 1) level.

Both flags are sticky. Once set, a flag stays set until software runs a two-step clear sequence. First it reads the status register while the flag is 1, which arms that flag. Then it performs a qualifying access. For the room flag, that access is a data-register write. For the done flag, it is a data-register write, a low-to-high transition of the transmitter enable (which queues a preamble), or a send-break request. The set condition always wins over the clear. A clearing write that leaves the buffer at or below the watermark therefore leaves the room flag set, and the arm is used up.

Buffer occupancy arrives as a count that leaves out the character currently in the shifter. The word written in the current cycle is added to that count inside the block. All pins are plain level or strobe controls, so there is no streaming handshake at the edge of the block.

Top module: `txflag_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `flag_room`, `flag_done` and `line_mark` are all 1.
- R2: At every clock edge where `tx_occ + data_wr` is less than or equal to `tx_watermark`, `flag_room` is 1 after that edge. This includes a watermark of 0 with an empty buffer.
- R3: `flag_room` goes to 0 only at the edge of a `data_wr` cycle, and only if a `stat_rd` has been taken while `flag_room` was 1 and no clearing access has occurred since, and `tx_occ + 1` exceeds the watermark.
- R4: A `data_wr` with no arming read since the previous clearing access leaves `flag_room` at 1.
- R5: A clearing write whose projected occupancy is still at or below the watermark leaves `flag_room` at 1 and uses up the arm. A later write without a fresh read does not clear the flag.
- R6: Once cleared, `flag_room` stays 0 while occupancy is above the watermark. Once set, it stays 1 while occupancy is above the watermark until a clear sequence is performed.
- R7: `flag_done` becomes 1 at the edge after a cycle with `tx_occ == 0`, `shifter_busy` low, no preamble or break pending, and no `data_wr`, `brk_req` or enable rising edge.
- R8: An armed read of `flag_done` followed by `data_wr` clears `flag_done`.
- R9: An armed read of `flag_done` followed by `tx_en` going from 0 to 1 clears `flag_done`. The queued preamble stays pending until `shifter_busy` is seen high.
- R10: An armed read of `flag_done` followed by a `brk_req` pulse clears `flag_done`. The break stays pending until `shifter_busy` is seen high.
- R11: A queueing access with no arming read leaves `flag_done` at 1. Once `flag_done` is 0, it stays 0 while the buffer is non-empty, the shifter is busy, or a preamble or break is pending.
- R12: `line_mark` is 1 exactly when `flag_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_occ | input | OCC_W | Words waiting in the transmit buffer, not counting the one in the shifter |
| tx_watermark | input | OCC_W | Programmed room watermark |
| shifter_busy | input | 1 | Shifter is sending a data, preamble or break character |
| tx_en | input | 1 | Transmitter enable control bit |
| brk_req | input | 1 | One-cycle strobe: software wrote 1 to the send-break bit |
| stat_rd | input | 1 | One-cycle strobe: status register read |
| data_wr | input | 1 | One-cycle strobe: data register write |
| flag_room | output | 1 | Buffer at or below watermark (sticky) |
| flag_done | output | 1 | Transmitter fully idle (sticky) |
| line_mark | output | 1 | Request to hold the serial line at logic 1 |

## Verification
The bench targets the clearing write that still leaves the buffer at or below the watermark. A design that let the clear beat the set would drop the room flag there and under-report space. The bench also checks a second write after that one. A design that did not use up the arm would clear the flag on that second write without a fresh read. A watermark of zero exercises the off-by-one between `<=` and `<`. The preamble and break paths check that the pending state keeps the done flag low across the gap before the shifter starts; a design without it would report completion while a break is still queued.

// File: rtl/txflag_pkg.sv
package txflag_pkg;
  localparam int unsigned TXF_DEPTH_DFLT = 16;
  localparam int unsigned TXF_NFLAG = 2;
  typedef enum int unsigned {
    FL_ROOM = 0,
    FL_DONE = 1
  } txf_idx_e;
endpackage

// File: rtl/txflag_cell.sv
module txflag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_cond,
  input  logic stat_rd,
  input  logic clr_evt,
  output logic flag,
  output logic armed
);
  logic fire;
  logic flag_d;
  logic armed_d;

  always_comb begin
    fire = armed & clr_evt;
    if (set_cond)  flag_d = 1'b1;
    else if (fire) flag_d = 1'b0;
    else           flag_d = flag;
    if (stat_rd)      armed_d = flag_d;
    else if (clr_evt) armed_d = 1'b0;
    else              armed_d = armed;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b1;
      armed <= 1'b0;
    end else begin
      flag  <= flag_d;
      armed <= armed_d;
    end
  end
endmodule

// File: rtl/txflag_activity.sv
module txflag_activity (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic brk_req,
  input  logic shifter_busy,
  output logic q_evt,
  output logic busy_pend
);
  logic en_q;
  logic pre_evt;

  assign pre_evt = tx_en & ~en_q;
  assign q_evt   = pre_evt | brk_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      busy_pend <= 1'b0;
    end else begin
      en_q <= tx_en;
      if (q_evt)             busy_pend <= 1'b1;
      else if (shifter_busy) busy_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/txflag_unit.sv
module txflag_unit #(
  parameter int unsigned DEPTH = txflag_pkg::TXF_DEPTH_DFLT,
  parameter int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCC_W-1:0] tx_occ,
  input  logic [OCC_W-1:0] tx_watermark,
  input  logic             shifter_busy,
  input  logic             tx_en,
  input  logic             brk_req,
  input  logic             stat_rd,
  input  logic             data_wr,
  output logic             flag_room,
  output logic             flag_done,
  output logic             line_mark
);
  import txflag_pkg::*;
  localparam int unsigned NF = TXF_NFLAG;

  logic [OCC_W:0] proj_occ;
  logic           room_set;
  logic           done_set;
  logic           q_evt;
  logic           busy_pend;
  logic [NF-1:0]  set_v;
  logic [NF-1:0]  clr_v;
  logic [NF-1:0]  flag_v;
  logic [NF-1:0]  arm_v;
  logic           room_armed;

  txflag_activity u_act (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_en        (tx_en),
    .brk_req      (brk_req),
    .shifter_busy (shifter_busy),
    .q_evt        (q_evt),
    .busy_pend    (busy_pend)
  );

  assign proj_occ = {1'b0, tx_occ} + {{OCC_W{1'b0}}, data_wr};
  assign room_set = proj_occ <= {1'b0, tx_watermark};
  assign done_set = (tx_occ == '0) & ~shifter_busy & ~busy_pend & ~q_evt & ~data_wr;

  always_comb begin
    set_v[FL_ROOM] = room_set;
    set_v[FL_DONE] = done_set;
    clr_v[FL_ROOM] = data_wr;
    clr_v[FL_DONE] = data_wr | q_evt;
  end

  for (genvar g = 0; g < NF; g++) begin : g_flag
    txflag_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_cond (set_v[g]),
      .stat_rd  (stat_rd),
      .clr_evt  (clr_v[g]),
      .flag     (flag_v[g]),
      .armed    (arm_v[g])
    );
  end

  assign flag_room  = flag_v[FL_ROOM];
  assign flag_done  = flag_v[FL_DONE];
  assign room_armed = arm_v[FL_ROOM];
  assign line_mark  = flag_done;
endmodule

// File: rtl/txflag_unit_chk.sv
module txflag_unit_chk #(
  parameter int unsigned OCC_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OCC_W-1:0] tx_occ,
  input logic [OCC_W-1:0] tx_watermark,
  input logic             shifter_busy,
  input logic             data_wr,
  input logic             flag_room,
  input logic             flag_done,
  input logic             room_armed,
  input logic             busy_pend,
  input logic             q_evt
);
  assert_room_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (({1'b0, tx_occ} + {{OCC_W{1'b0}}, data_wr}) <= {1'b0, tx_watermark}) |=> flag_room);

  assert_room_falls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_room) |-> $past(data_wr));

  assert_arm_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    room_armed |-> flag_room);

  assert_done_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_occ == '0 && !shifter_busy && !busy_pend && !q_evt && !data_wr) |=> flag_done);

  assert_done_falls_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_done) |-> $past(data_wr || q_evt));

  assert_done_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_done && (shifter_busy || busy_pend)) |=> !flag_done);
endmodule

bind txflag_unit txflag_unit_chk #(.OCC_W(OCC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_occ       (tx_occ),
  .tx_watermark (tx_watermark),
  .shifter_busy (shifter_busy),
  .data_wr      (data_wr),
  .flag_room    (flag_room),
  .flag_done    (flag_done),
  .room_armed   (room_armed),
  .busy_pend    (busy_pend),
  .q_evt        (q_evt)
);

// File: tb/test_txflag_unit.sv
`timescale 1ns/1ps
module test_txflag_unit;
  localparam int unsigned W = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] tx_occ = '0;
  logic [W-1:0] tx_watermark = 5'd2;
  logic         shifter_busy = 1'b0;
  logic         tx_en = 1'b0;
  logic         brk_req = 1'b0;
  logic         stat_rd = 1'b0;
  logic         data_wr = 1'b0;
  logic         flag_room;
  logic         flag_done;
  logic         line_mark;

  int n_chk = 0;
  int n_bad = 0;
  bit done_run = 1'b0;

  always #2 clk = ~clk;

  txflag_unit i_txflag_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_occ       (tx_occ),
    .tx_watermark (tx_watermark),
    .shifter_busy (shifter_busy),
    .tx_en        (tx_en),
    .brk_req      (brk_req),
    .stat_rd      (stat_rd),
    .data_wr      (data_wr),
    .flag_room    (flag_room),
    .flag_done    (flag_done),
    .line_mark    (line_mark)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd_pulse();
    stat_rd = 1'b1; tick(); stat_rd = 1'b0;
  endtask

  task automatic wr_pulse();
    data_wr = 1'b1; tick(); data_wr = 1'b0;
  endtask

  task automatic settle(input logic [W-1:0] wm);
    tx_watermark = wm; tx_occ = '0; shifter_busy = 1'b0;
    stat_rd = 1'b0; data_wr = 1'b0; brk_req = 1'b0;
    tick();
    wr_pulse();
    tick(); tick();
  endtask

  task automatic t_reset();
    check("R1 room in reset", flag_room, 1'b1);
    check("R1 done in reset", flag_done, 1'b1);
    rst_n = 1'b1;
    tick();
    check("R1 room after reset", flag_room, 1'b1);
    check("R1 done after reset", flag_done, 1'b1);
    check("R1 mark after reset", line_mark, 1'b1);
  endtask

  task automatic t_room_clear();
    settle(5'd2);
    tx_occ = 5'd3; tick();
    check("R6 room sticky high", flag_room, 1'b1);
    rd_pulse();
    wr_pulse();
    check("R3 armed write clears room", flag_room, 1'b0);
    tx_occ = 5'd4; tick(); tick();
    check("R6 room stays low", flag_room, 1'b0);
    tx_occ = 5'd2; tick();
    check("R2 room sets at watermark", flag_room, 1'b1);
  endtask

  task automatic t_room_no_arm();
    settle(5'd2);
    tx_occ = 5'd3; tick();
    wr_pulse();
    check("R4 unarmed write keeps room", flag_room, 1'b1);
    check("R11 unarmed write keeps done", flag_done, 1'b1);
  endtask

  task automatic t_room_reassert();
    settle(5'd2);
    tx_occ = 5'd1; tick();
    rd_pulse();
    wr_pulse();
    check("R5 write at watermark keeps room", flag_room, 1'b1);
    tx_occ = 5'd2; tick();
    wr_pulse();
    check("R5 arm used up", flag_room, 1'b1);
    rd_pulse();
    wr_pulse();
    check("R3 fresh arm clears room", flag_room, 1'b0);
  endtask

  task automatic t_wm_zero();
    settle(5'd0);
    check("R2 room at zero watermark", flag_room, 1'b1);
    rd_pulse();
    wr_pulse();
    check("R3 room clears with zero watermark", flag_room, 1'b0);
    tx_occ = 5'd1; tick();
    check("R6 room low with one word", flag_room, 1'b0);
    tx_occ = 5'd0; tick();
    check("R2 room sets when drained", flag_room, 1'b1);
    check("R7 done sets when drained", flag_done, 1'b1);
  endtask

  task automatic t_done_write();
    settle(5'd2);
    rd_pulse();
    wr_pulse();
    check("R8 write clears done", flag_done, 1'b0);
    check("R12 mark follows done low", line_mark, 1'b0);
    tx_occ = 5'd1; tick();
    check("R11 done low while buffer holds data", flag_done, 1'b0);
    tx_occ = 5'd0; shifter_busy = 1'b1; tick();
    check("R11 done low while shifting", flag_done, 1'b0);
    shifter_busy = 1'b0; tick();
    check("R7 done sets when idle", flag_done, 1'b1);
    check("R12 mark follows done high", line_mark, 1'b1);
  endtask

  task automatic t_done_preamble();
    settle(5'd2);
    tx_en = 1'b0; tick();
    rd_pulse();
    tx_en = 1'b1; tick();
    check("R9 enable rise clears done", flag_done, 1'b0);
    tick();
    check("R9 preamble pending holds done", flag_done, 1'b0);
    shifter_busy = 1'b1; tick();
    shifter_busy = 1'b0; tick();
    check("R7 done sets after preamble", flag_done, 1'b1);
  endtask

  task automatic t_done_break();
    settle(5'd2);
    rd_pulse();
    brk_req = 1'b1; tick(); brk_req = 1'b0;
    check("R10 break clears done", flag_done, 1'b0);
    tick();
    check("R10 break pending holds done", flag_done, 1'b0);
    shifter_busy = 1'b1; tick();
    shifter_busy = 1'b0; tick();
    check("R7 done sets after break", flag_done, 1'b1);
  endtask

  task automatic t_done_unarmed_break();
    settle(5'd2);
    brk_req = 1'b1; tick(); brk_req = 1'b0;
    check("R11 unarmed break keeps done", flag_done, 1'b1);
    shifter_busy = 1'b1; tick();
    shifter_busy = 1'b0; tick();
    check("R11 done still set", flag_done, 1'b1);
  endtask

  initial begin
    tick(); tick();
    t_reset();
    t_room_clear();
    t_room_no_arm();
    t_room_reassert();
    t_wm_zero();
    t_done_write();
    t_done_preamble();
    t_done_break();
    t_done_unarmed_break();
    done_run = 1'b1;
  end

  initial begin
    fork
      wait (done_run);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule